// File: doc/BRIEF.md
# Register Vector-Tag Context Tracker

This block holds the vector/scalar tagging context that applies to the registers used inside one vector block of instructions. A block header supplies two source tag flags, and optionally an explicit destination tag, together with an activation offset measured in 16-bit parcels. The first instruction decoded at that offset binds its register numbers to those flags. Every instruction after it is classified against that small bound set.

For each later instruction, an operand whose register is bound reports its bound tag. An operand whose register is not bound takes the OR of the tags of the bound operands in the same instruction. A tag computed in this way is not stored, so the whole context can be rebuilt from the header and the binding instruction alone. The decoder presents one decoded instruction per strobe. The classification for that instruction appears on registered outputs one cycle later. A block-end pulse discards the context.

Top module: `vtag_tracker`

## Requirements
- R1: After reset, `outValid` and all three vector outputs are 0, and no register is bound.
- R2: An instruction strobed on `instValid` while `blockEnd` is low produces `outValid` high exactly one cycle later. The vector outputs change only in that cycle and hold their value otherwise.
- R3: While no binding exists, an instruction whose `parcelCount` differs from `activateOffset` reports all operands scalar and creates no binding.
- R4: While no binding exists, an instruction with `parcelCount == activateOffset` binds rs1 to `srcTag1` and rs2 to `srcTag2`, and reports those tags on its own rs1 and rs2 outputs.
- R5: The binding instruction's rd receives `dstTag` when `dstTagGiven` is 1, and `srcTag1 | srcTag2` otherwise. The same value is reported on its rd output.
- R6: In a later instruction, an operand whose register is bound reports its bound tag. If the binding instruction named the same register more than once, the rs1 binding takes precedence over the rs2 binding, which takes precedence over the rd binding.
- R7: In a later instruction, an operand whose register is not bound reports the OR of the tags of the bound operands of that same instruction.
- R8: A later instruction with no bound operand reports all operands scalar.
- R9: A tag derived under R7 is not remembered. A register that reported vector in one instruction reports scalar in a later one when no bound operand accompanies it.
- R10: Register 0, and any operand whose valid bit is 0, always reports scalar. Such an operand is never bound and does not contribute to the OR of R7.
- R11: `blockEnd` clears all bindings. An instruction strobed in the same cycle is discarded, with no `outValid`. A later instruction must match the offset again before a new binding is made.
- R12: Once a binding exists, `parcelCount` and `activateOffset` have no effect on classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | One-cycle strobe for a decoded instruction |
| rdNum | input | 5 | Destination register number |
| rdValid | input | 1 | Destination operand present |
| rs1Num | input | 5 | First source register number |
| rs1Valid | input | 1 | First source operand present |
| rs2Num | input | 5 | Second source register number |
| rs2Valid | input | 1 | Second source operand present |
| srcTag1 | input | 1 | Header tag for the first source |
| srcTag2 | input | 1 | Header tag for the second source |
| dstTagGiven | input | 1 | Header carries an explicit destination tag |
| dstTag | input | 1 | Explicit destination tag |
| parcelCount | input | PC_W | Position of the instruction within the block, in 16-bit parcels |
| activateOffset | input | PC_W | Parcel position at which the header takes effect |
| blockEnd | input | 1 | Pulse that ends the block and clears the context |
| outValid | output | 1 | Classification of the previous strobed instruction is present |
| rdVec | output | 1 | Destination operand is a vector |
| rs1Vec | output | 1 | First source operand is a vector |
| rs2Vec | output | 1 | Second source operand is a vector |

## Verification
The assertions take for granted that `instValid` and `blockEnd` are one-cycle pulses with known values, and that the header inputs stay constant while a block is open. The bench drives every input on the falling edge. It pulses each strobe for exactly one cycle and changes the header only after a `blockEnd`. It draws register numbers from a five-element set that includes register 0. This forces repeated numbers, collisions with the bound set and x0 on every operand, and the sweep covers all operand valid masks and all header flag combinations.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int REG_W     = 5;
  localparam int NUM_OPS   = 3;   // operand order: 0 = rs1, 1 = rs2, 2 = rd
  localparam int NUM_SLOTS = NUM_OPS;

  typedef logic [REG_W-1:0] regNum_t;

  typedef struct packed {
    logic    valid;
    regNum_t num;
    logic    tag;
  } slot_t;

  typedef struct packed {
    logic bindEn;    // first instruction at activation
    logic lookupEn;  // instruction classified against bound set
    logic passEn;    // instruction before activation: all scalar
    logic clearEn;   // block end
  } ctrlStrobe_t;
endpackage

// File: rtl/vtag_ctrl.sv
module vtag_ctrl
  import vtag_pkg::*;
#(
  parameter int PC_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic            blockEnd,
  input  logic [PC_W-1:0] parcelCount,
  input  logic [PC_W-1:0] activateOffset,
  output ctrlStrobe_t     strobe
);
  logic bound;
  logic atOffset;

  assign atOffset = (parcelCount == activateOffset);

  always_comb begin
    strobe = '0;
    if (blockEnd) begin
      strobe.clearEn = 1'b1;
    end else if (instValid) begin
      if (bound)         strobe.lookupEn = 1'b1;
      else if (atOffset) strobe.bindEn   = 1'b1;
      else               strobe.passEn   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               bound <= 1'b0;
    else if (strobe.clearEn) bound <= 1'b0;
    else if (strobe.bindEn)  bound <= 1'b1;
  end

  // R11: a block-end pulse leaves no binding behind
  a_r11_clear: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |=> !bound);

  // R12: once bound, only block end removes the binding
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bound && !blockEnd) |=> bound);

  // R3: a mismatched parcel position never creates a binding
  a_r3_no_bind: assert property (@(posedge clk) disable iff (!rstN)
    (!bound && instValid && !blockEnd && !atOffset) |=> !bound);

  // R2: at most one action per cycle
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/vtag_lookup.sv
module vtag_lookup
  import vtag_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  slot_t [SLOTS-1:0] slots,
  input  logic              opValid,
  input  regNum_t           opNum,
  output logic              hit,
  output logic              hitTag
);
  // lowest slot index wins: scan downward so the last write is slot 0
  always_comb begin
    hit    = 1'b0;
    hitTag = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (opValid && (opNum != '0) && slots[i].valid && (slots[i].num == opNum)) begin
        hit    = 1'b1;
        hitTag = slots[i].tag;
      end
    end
  end
endmodule

// File: rtl/vtag_datapath.sv
module vtag_datapath
  import vtag_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [NUM_OPS-1:0]    opValid,
  input  regNum_t [NUM_OPS-1:0] opNum,
  input  logic                  srcTag1,
  input  logic                  srcTag2,
  input  logic                  dstTagGiven,
  input  logic                  dstTag,
  output logic                  outValid,
  output logic [NUM_OPS-1:0]    opVec
);
  slot_t [NUM_SLOTS-1:0] slots;
  logic  [NUM_OPS-1:0]   usable;
  logic  [NUM_OPS-1:0]   bindTag;
  logic  [NUM_OPS-1:0]   hit;
  logic  [NUM_OPS-1:0]   hitTag;
  logic                  hitOr;
  logic                  anyHit;
  logic                  anyInst;
  logic  [NUM_OPS-1:0]   nextVec;

  assign bindTag[0] = srcTag1;
  assign bindTag[1] = srcTag2;
  assign bindTag[2] = dstTagGiven ? dstTag : (srcTag1 | srcTag2);

  assign anyInst = strobe.bindEn | strobe.lookupEn | strobe.passEn;
  assign hitOr   = |(hit & hitTag);
  assign anyHit  = |hit;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    assign usable[k] = opValid[k] && (opNum[k] != '0);

    vtag_lookup #(.SLOTS(NUM_SLOTS)) u_look (
      .slots  (slots),
      .opValid(opValid[k]),
      .opNum  (opNum[k]),
      .hit    (hit[k]),
      .hitTag (hitTag[k])
    );

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearEn) begin
        slots[k] <= '0;
      end else if (strobe.bindEn) begin
        slots[k].valid <= usable[k];
        slots[k].num   <= opNum[k];
        slots[k].tag   <= bindTag[k];
      end
    end

    // R10: register 0 never occupies a slot
    a_r10_no_x0_slot: assert property (@(posedge clk) disable iff (!rstN)
      slots[k].valid |-> (slots[k].num != '0));

    // R10: absent or x0 operands report scalar
    a_r10_scalar_op: assert property (@(posedge clk) disable iff (!rstN)
      (anyInst && !usable[k]) |=> !opVec[k]);
  end

  always_comb begin
    nextVec = '0;
    if (strobe.bindEn) begin
      nextVec = usable & bindTag;
    end else if (strobe.lookupEn) begin
      for (int k = 0; k < NUM_OPS; k++) begin
        nextVec[k] = usable[k] && (hit[k] ? hitTag[k] : hitOr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      opVec    <= '0;
    end else begin
      outValid <= anyInst;
      if (anyInst) opVec <= nextVec;
    end
  end

  // R2: result strobe follows each accepted instruction by one cycle
  a_r2_valid: assert property (@(posedge clk) disable iff (!rstN)
    anyInst |=> outValid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !anyInst |=> (!outValid && $stable(opVec)));

  // R8: no bound operand means an all-scalar result
  a_r8_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookupEn && !anyHit) |=> (opVec == '0));

  // R3: pre-activation instructions are all scalar
  a_r3_pass_scalar: assert property (@(posedge clk) disable iff (!rstN)
    strobe.passEn |=> (opVec == '0));
endmodule

// File: rtl/vtag_tracker.sv
module vtag_tracker
  import vtag_pkg::*;
#(
  parameter int PC_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [4:0]      rdNum,
  input  logic            rdValid,
  input  logic [4:0]      rs1Num,
  input  logic            rs1Valid,
  input  logic [4:0]      rs2Num,
  input  logic            rs2Valid,
  input  logic            srcTag1,
  input  logic            srcTag2,
  input  logic            dstTagGiven,
  input  logic            dstTag,
  input  logic [PC_W-1:0] parcelCount,
  input  logic [PC_W-1:0] activateOffset,
  input  logic            blockEnd,
  output logic            outValid,
  output logic            rdVec,
  output logic            rs1Vec,
  output logic            rs2Vec
);
  ctrlStrobe_t           strobe;
  regNum_t [NUM_OPS-1:0] opNum;
  logic [NUM_OPS-1:0]    opValid;
  logic [NUM_OPS-1:0]    opVec;

  assign opNum   = {rdNum, rs2Num, rs1Num};
  assign opValid = {rdValid, rs2Valid, rs1Valid};
  assign rs1Vec  = opVec[0];
  assign rs2Vec  = opVec[1];
  assign rdVec   = opVec[2];

  vtag_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .instValid     (instValid),
    .blockEnd      (blockEnd),
    .parcelCount   (parcelCount),
    .activateOffset(activateOffset),
    .strobe        (strobe)
  );

  vtag_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opValid    (opValid),
    .opNum      (opNum),
    .srcTag1    (srcTag1),
    .srcTag2    (srcTag2),
    .dstTagGiven(dstTagGiven),
    .dstTag     (dstTag),
    .outValid   (outValid),
    .opVec      (opVec)
  );

  // R11: an instruction coinciding with block end yields no result
  a_r11_drop: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |=> !outValid);
endmodule

// File: tb/sim_vtag_tracker.sv
module sim_vtag_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [4:0] rdNum = '0, rs1Num = '0, rs2Num = '0;
  logic rdValid = 1'b0, rs1Valid = 1'b0, rs2Valid = 1'b0;
  logic srcTag1 = 1'b0, srcTag2 = 1'b0, dstTagGiven = 1'b0, dstTag = 1'b0;
  logic [PC_W-1:0] parcelCount = '0, activateOffset = '0;
  logic blockEnd = 1'b0;
  logic outValid, rdVec, rs1Vec, rs2Vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference context: index 0 = rs1, 1 = rs2, 2 = rd
  bit       mBound = 1'b0;
  bit       mValid [3];
  bit [4:0] mNum   [3];
  bit       mTag   [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  vtag_tracker #(.PC_W(PC_W)) u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .rdNum(rdNum), .rdValid(rdValid), .rs1Num(rs1Num), .rs1Valid(rs1Valid),
    .rs2Num(rs2Num), .rs2Valid(rs2Valid), .srcTag1(srcTag1), .srcTag2(srcTag2),
    .dstTagGiven(dstTagGiven), .dstTag(dstTag), .parcelCount(parcelCount),
    .activateOffset(activateOffset), .blockEnd(blockEnd),
    .outValid(outValid), .rdVec(rdVec), .rs1Vec(rs1Vec), .rs2Vec(rs2Vec)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,rd,rs1,rs2} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic setHeader(input bit t1, input bit t2, input bit dg, input bit dt,
                           input logic [PC_W-1:0] off);
    srcTag1 = t1; srcTag2 = t2; dstTagGiven = dg; dstTag = dt; activateOffset = off;
  endtask

  task automatic endBlock(input string req);
    @(negedge clk);
    blockEnd = 1'b1;
    @(negedge clk);
    blockEnd = 1'b0;
    mBound = 1'b0;
    check(req, {outValid, rdVec, rs1Vec, rs2Vec}, {1'b0, rdVec, rs1Vec, rs2Vec});
  endtask

  // issue one instruction, predict, and compare one cycle later
  task automatic doInst(input string req, input logic [4:0] d, input logic [4:0] s1,
                        input logic [4:0] s2, input logic [2:0] vmask,
                        input logic [PC_W-1:0] pc);
    bit [4:0] n[3];
    bit v[3], use_[3], h[3], ht[3], e[3];
    bit orAll;
    n[0] = s1; n[1] = s2; n[2] = d;
    v[0] = vmask[0]; v[1] = vmask[1]; v[2] = vmask[2];
    for (int k = 0; k < 3; k++) begin
      use_[k] = v[k] && (n[k] != 5'd0);
      e[k] = 1'b0;
    end
    if (!mBound) begin
      if (pc == activateOffset) begin
        mBound = 1'b1;
        mTag[0] = srcTag1; mTag[1] = srcTag2;
        mTag[2] = dstTagGiven ? dstTag : (srcTag1 | srcTag2);
        for (int k = 0; k < 3; k++) begin
          mValid[k] = use_[k]; mNum[k] = n[k];
          e[k] = use_[k] && mTag[k];
        end
      end
    end else begin
      orAll = 1'b0;
      for (int k = 0; k < 3; k++) begin
        h[k] = 1'b0; ht[k] = 1'b0;
        for (int j = 2; j >= 0; j--)
          if (use_[k] && mValid[j] && mNum[j] == n[k]) begin h[k] = 1'b1; ht[k] = mTag[j]; end
        orAll |= h[k] && ht[k];
      end
      for (int k = 0; k < 3; k++) e[k] = use_[k] && (h[k] ? ht[k] : orAll);
    end
    @(negedge clk);
    rdNum = d; rs1Num = s1; rs2Num = s2;
    rs1Valid = vmask[0]; rs2Valid = vmask[1]; rdValid = vmask[2];
    parcelCount = pc; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    check(req, {outValid, rdVec, rs1Vec, rs2Vec}, {1'b1, e[2], e[0], e[1]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] pool [5];
    pool[0] = 5'd0; pool[1] = 5'd3; pool[2] = 5'd5; pool[3] = 5'd7; pool[4] = 5'd12;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {outValid, rdVec, rs1Vec, rs2Vec}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {outValid, rdVec, rs1Vec, rs2Vec}, 4'b0000);

    // R3: before the activation offset every operand is scalar
    setHeader(1, 1, 0, 0, 6'd4);
    doInst("R3", 5'd3, 5'd5, 5'd12, 3'b111, 6'd0);
    doInst("R3", 5'd3, 5'd5, 5'd12, 3'b111, 6'd2);
    // R2: outputs hold after the result cycle
    @(negedge clk);
    check("R2", {outValid, rdVec, rs1Vec, rs2Vec}, 4'b0000);

    // R4, R5: worked case, vs1=1 vs2=0, implicit destination
    setHeader(1, 0, 0, 0, 6'd4);
    doInst("R4", 5'd3, 5'd5, 5'd12, 3'b111, 6'd4);
    check("R5", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1110);
    doInst("R7", 5'd7, 5'd5, 5'd3, 3'b111, 6'd6);
    check("R7", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1111);
    doInst("R8", 5'd9, 5'd4, 5'd4, 3'b111, 6'd8);
    check("R8", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    doInst("R9", 5'd7, 5'd5, 5'd4, 3'b111, 6'd10);
    check("R9", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1111);
    doInst("R9", 5'd7, 5'd9, 5'd4, 3'b111, 6'd12);
    check("R9", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    doInst("R7", 5'd7, 5'd12, 5'd4, 3'b111, 6'd14);
    check("R7", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    // R12: parcel counter back at the offset with other registers, no rebinding
    doInst("R12", 5'd9, 5'd4, 5'd8, 3'b111, 6'd4);
    check("R12", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    endBlock("R11");

    // R11: block end with a coincident instruction drops it and clears
    @(negedge clk);
    setHeader(1, 1, 0, 0, 6'd1);
    doInst("R4", 5'd3, 5'd5, 5'd12, 3'b111, 6'd1);
    @(negedge clk);
    blockEnd = 1'b1; instValid = 1'b1; rs1Num = 5'd5; parcelCount = 6'd1;
    @(negedge clk);
    blockEnd = 1'b0; instValid = 1'b0; mBound = 1'b0;
    check("R11", {outValid, 3'b000}, 4'b0000);
    doInst("R11", 5'd3, 5'd5, 5'd12, 3'b111, 6'd2);
    check("R11", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    endBlock("R11");

    // R6: duplicate register in the binding instruction, rs1 binding wins
    setHeader(1, 0, 1, 0, 6'd0);
    doInst("R6", 5'd6, 5'd6, 5'd6, 3'b111, 6'd0);
    check("R6", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1010);
    doInst("R6", 5'd8, 5'd6, 5'd9, 3'b111, 6'd2);
    check("R6", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1111);
    endBlock("R11");

    // R10: x0 and absent operands never bind and never contribute
    setHeader(1, 1, 0, 0, 6'd0);
    doInst("R10", 5'd0, 5'd0, 5'd12, 3'b101, 6'd0);
    check("R10", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    doInst("R10", 5'd7, 5'd0, 5'd12, 3'b111, 6'd2);
    check("R10", {1'b1, rdVec, rs1Vec, rs2Vec}, 4'b1000);
    endBlock("R11");

    // sweep: every header flag combination, every operand mask and register mix
    for (int f = 0; f < 16; f++) begin
      setHeader(f[0], f[1], f[2], f[3], 6'(f * 3));
      doInst("R3", 5'd3, 5'd5, 5'd12, 3'b111, 6'(f * 3 + 1));
      doInst("R4", 5'd3, 5'd5, 5'd12, 3'b111, 6'(f * 3));
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int c = 0; c < 5; c++)
            for (int m = 0; m < 8; m++)
              doInst("R7", pool[a], pool[b], pool[c], 3'(m), 6'(a + b + c + m));
      endBlock("R11");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule